// File: doc/BRIEF.md
# Chroma Subsampler and Restorer

This block sits on a pixel stream between a pixel port and a strip buffer. It thins out or rebuilds the chroma samples. In the compress direction each incoming pixel carries a luma sample and a U/V pair. The block forwards every luma sample and keeps chroma only on the pixels that the selected subsampling pattern allows. A flag marks the output samples that still carry chroma.

In the expand direction the input stream has the reduced layout. Chroma is meaningful only at the pixel positions that the pattern keeps. The block rebuilds a full U/V pair for every pixel by repeating the most recent kept pair, with no interpolation. The vertical pattern drops chroma on every second line. On expansion it fills those lines from a line store that holds the chroma rebuilt on the line before.

The pattern and the direction are captured at each frame start and stay fixed for the rest of the frame. A line parity tracker counts lines from the frame start, and a pixel index counts pixels from each line start.

Top module: `chroma_resampler`

## Requirements
- R1: `valid_o` equals `pix_valid_i` delayed by one clock, and on each valid output `y_o` equals the `y_i` of the pixel one clock earlier, in every mode and direction. After reset `valid_o` and `cvld_o` are 0.
- R2: Compress, mode 0 (luma only): every output sample has `cvld_o`=0 and chroma outputs 0.
- R3: Compress, mode 1 (horizontal halving): pixel index 0 is the first pixel after `line_start_i`. Samples with an even index have `cvld_o`=1 and `u_o`/`v_o` equal to the input pair. Odd-index samples carry no chroma.
- R4: Compress, mode 3 (horizontal quartering): chroma is kept only on pixels whose index is a multiple of 4.
- R5: Compress, mode 2 (halving in both directions): lines are numbered from 1 after `frame_start_i`, with each `line_start_i` advancing the count. Odd lines follow the R3 pattern. Even lines carry no chroma.
- R6: Whenever a valid output has `cvld_o`=0, `u_o` and `v_o` are 0. `cvld_o` is never 1 without `valid_o`.
- R7: Expand, modes 1 and 3: every sample has `cvld_o`=1. At kept positions the chroma is taken from the input. At the other positions the input chroma is ignored and the last kept pair of the line is repeated.
- R8: Expand, mode 2: odd lines behave as R7 with the mode 1 pattern. On even lines the input chroma is ignored, and each pixel receives the chroma that was output at the same index on the previous line.
- R9: Expand, mode 0: every sample has `cvld_o`=0 and zero chroma.
- R10: `mode_i` (0..3 as above) and `dir_i` (0 = compress, 1 = expand) are sampled only in a cycle with `frame_start_i`=1. Changes at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Subsampling pattern, captured at frame start |
| dir_i | input | 1 | 0 compress, 1 expand, captured at frame start |
| frame_start_i | input | 1 | Frame start strobe |
| line_start_i | input | 1 | Line start strobe |
| pix_valid_i | input | 1 | Pixel present on the data inputs |
| y_i | input | DW | Luma sample |
| u_i | input | DW | U sample |
| v_i | input | DW | V sample |
| valid_o | output | 1 | Output sample valid |
| cvld_o | output | 1 | Output sample carries chroma |
| y_o | output | DW | Luma out |
| u_o | output | DW | U out |
| v_o | output | DW | V out |

## Verification
The assertions assume three things about the inputs. A pixel never arrives in the same cycle as a frame or line start. A line holds no more than MAX_W pixels. Within a frame, every even line in the vertical mode is no longer than the line before it. The stimulus follows all three. It places each strobe in an idle cycle of its own, uses one line width per frame that is well below MAX_W, and inserts idle gaps at random between pixels. Outside the frame-start cycles, the bench sometimes toggles the mode and direction inputs to random values. It also feeds random chroma at positions the pattern does not keep, to show that those values are ignored.

// File: rtl/chroma_rs_pkg.sv
// Shared types and helpers for the chroma subsampler/restorer.
// Assumes the pixel index carries at least two bits.
package chroma_rs_pkg;

    typedef enum logic [1:0] {
        CR_LUMA = 2'd0,
        CR_H2   = 2'd1,
        CR_V2   = 2'd2,
        CR_H4   = 2'd3
    } cr_mode_e;

    // True when the column pattern of the mode keeps chroma at this index.
    function automatic logic cr_col_keeps(cr_mode_e m, logic [1:0] idx_lsb);
        case (m)
            CR_H2, CR_V2: return (idx_lsb[0] == 1'b0);
            CR_H4:        return (idx_lsb == 2'b00);
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cr_frame_track.sv
// Frame and line tracking: captures mode and direction at frame start,
// keeps the line parity (first line of a frame is odd) and the pixel
// index inside a line. Assumes pixels never share a cycle with a strobe.
module cr_frame_track
    import chroma_rs_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start_i,
    input  logic          line_start_i,
    input  logic          pix_valid_i,
    input  logic [1:0]    mode_i,
    input  logic          dir_i,
    output cr_mode_e      mode_o,
    output logic          dir_o,
    output logic          line_odd_o,
    output logic [IW-1:0] idx_o
);

    // Capture configuration only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= CR_LUMA;
            dir_o  <= 1'b0;
        end else if (frame_start_i) begin
            mode_o <= cr_mode_e'(mode_i);
            dir_o  <= dir_i;
        end
    end

    // Line parity: frame start clears it, each line start flips it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_odd_o <= 1'b0;
        else if (frame_start_i)
            line_odd_o <= line_start_i;
        else if (line_start_i)
            line_odd_o <= ~line_odd_o;
    end

    // Pixel index within the current line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_o <= '0;
        else if (line_start_i)
            idx_o <= '0;
        else if (pix_valid_i)
            idx_o <= idx_o + 1'b1;
    end

endmodule

// File: rtl/cr_line_store.sv
// Single-line chroma store: synchronous write, combinational read.
// Contents are undefined until written; readers must write a line first.
module cr_line_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int WW    = 16
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [WW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [WW-1:0] rdata_o
);

    logic [WW-1:0] mem [DEPTH];

    // Write one entry per accepted pixel.
    always_ff @(posedge clk) begin
        if (we_i)
            mem[waddr_i] <= wdata_i;
    end

    // Read the entry for the current pixel position.
    always_comb rdata_o = mem[raddr_i];

endmodule

// File: rtl/cr_chroma_sel.sv
// Chroma selection for both directions. Compress keeps or zeroes the
// input pair. Expand takes it at kept positions, repeats the held pair
// elsewhere, and reads the line store on the dropped lines of the
// vertical mode. Assumes the line store read data matches idx_i.
module cr_chroma_sel
    import chroma_rs_pkg::*;
#(
    parameter int DW = 8,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cr_mode_e      mode_i,
    input  logic          dir_i,
    input  logic          line_odd_i,
    input  logic [IW-1:0] idx_i,
    input  logic          pix_valid_i,
    input  logic [DW-1:0] u_i,
    input  logic [DW-1:0] v_i,
    input  logic [2*DW-1:0] store_rd_i,
    output logic          cvld_o,
    output logic [DW-1:0] u_o,
    output logic [DW-1:0] v_o,
    output logic          store_we_o,
    output logic [2*DW-1:0] store_wd_o
);

    logic          col_keep;
    logic          row_keep;
    logic [DW-1:0] hold_u;
    logic [DW-1:0] hold_v;

    // Position tests for the current pixel.
    always_comb begin
        col_keep = cr_col_keeps(mode_i, idx_i[1:0]);
        row_keep = (mode_i != CR_V2) || line_odd_i;
    end

    // Pick the output chroma for the current pixel.
    always_comb begin
        cvld_o = 1'b0;
        u_o    = '0;
        v_o    = '0;
        if (!dir_i) begin
            if (col_keep && row_keep) begin
                cvld_o = 1'b1;
                u_o    = u_i;
                v_o    = v_i;
            end
        end else if (mode_i != CR_LUMA) begin
            cvld_o = 1'b1;
            if (!row_keep) begin
                u_o = store_rd_i[2*DW-1:DW];
                v_o = store_rd_i[DW-1:0];
            end else if (col_keep) begin
                u_o = u_i;
                v_o = v_i;
            end else begin
                u_o = hold_u;
                v_o = hold_v;
            end
        end
    end

    // Keep the most recent kept pair for horizontal repetition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_u <= '0;
            hold_v <= '0;
        end else if (pix_valid_i && dir_i && col_keep && row_keep) begin
            hold_u <= u_i;
            hold_v <= v_i;
        end
    end

    // Record the rebuilt chroma of kept lines in vertical expand mode.
    always_comb begin
        store_we_o = pix_valid_i && dir_i && (mode_i == CR_V2) && line_odd_i;
        store_wd_o = {u_o, v_o};
    end

endmodule

// File: rtl/chroma_resampler.sv
// Top of the chroma subsampler/restorer. One register stage from input
// pixel to output sample. Assumes MAX_W >= 4, that no line exceeds MAX_W
// pixels, and that pixels never coincide with frame or line strobes.
module chroma_resampler
    import chroma_rs_pkg::*;
#(
    parameter int DW    = 8,
    parameter int MAX_W = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          dir_i,
    input  logic          frame_start_i,
    input  logic          line_start_i,
    input  logic          pix_valid_i,
    input  logic [DW-1:0] y_i,
    input  logic [DW-1:0] u_i,
    input  logic [DW-1:0] v_i,
    output logic          valid_o,
    output logic          cvld_o,
    output logic [DW-1:0] y_o,
    output logic [DW-1:0] u_o,
    output logic [DW-1:0] v_o
);

    localparam int IW = (MAX_W > 4) ? $clog2(MAX_W) : 2;

    cr_mode_e        act_mode;
    logic            act_dir;
    logic            line_odd;
    logic [IW-1:0]   pix_idx;
    logic            sel_cvld;
    logic [DW-1:0]   sel_u;
    logic [DW-1:0]   sel_v;
    logic            st_we;
    logic [2*DW-1:0] st_wd;
    logic [2*DW-1:0] st_rd;

    cr_frame_track #(.IW(IW)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .line_start_i  (line_start_i),
        .pix_valid_i   (pix_valid_i),
        .mode_i        (mode_i),
        .dir_i         (dir_i),
        .mode_o        (act_mode),
        .dir_o         (act_dir),
        .line_odd_o    (line_odd),
        .idx_o         (pix_idx)
    );

    cr_line_store #(.DEPTH(MAX_W), .AW(IW), .WW(2*DW)) u_store (
        .clk     (clk),
        .we_i    (st_we),
        .waddr_i (pix_idx),
        .wdata_i (st_wd),
        .raddr_i (pix_idx),
        .rdata_o (st_rd)
    );

    cr_chroma_sel #(.DW(DW), .IW(IW)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (act_mode),
        .dir_i       (act_dir),
        .line_odd_i  (line_odd),
        .idx_i       (pix_idx),
        .pix_valid_i (pix_valid_i),
        .u_i         (u_i),
        .v_i         (v_i),
        .store_rd_i  (st_rd),
        .cvld_o      (sel_cvld),
        .u_o         (sel_u),
        .v_o         (sel_v),
        .store_we_o  (st_we),
        .store_wd_o  (st_wd)
    );

    // Output stage: strobe every cycle, data only on accepted pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            cvld_o  <= 1'b0;
            y_o     <= '0;
            u_o     <= '0;
            v_o     <= '0;
        end else begin
            valid_o <= pix_valid_i;
            cvld_o  <= pix_valid_i && sel_cvld;
            if (pix_valid_i) begin
                y_o <= y_i;
                u_o <= sel_u;
                v_o <= sel_v;
            end
        end
    end

endmodule

// File: rtl/chroma_resampler_chk.sv
// Property checker for chroma_resampler, bound to every instance.
// Assumes the input rules stated at the top module.
module chroma_resampler_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start_i,
    input logic          pix_valid_i,
    input logic [DW-1:0] y_i,
    input logic          valid_o,
    input logic          cvld_o,
    input logic [DW-1:0] y_o,
    input logic [DW-1:0] u_o,
    input logic [DW-1:0] v_o,
    input logic [1:0]    act_mode,
    input logic          act_dir,
    input logic          line_odd
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> valid_o);                                                    // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !valid_o);                                                  // R1
    AST_LUMA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> (y_o == $past(y_i)));                                        // R1
    AST_LUMA_ONLY_NO_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && act_mode == 2'd0) |=> !cvld_o);                              // R2
    AST_V2_ROW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && !act_dir && act_mode == 2'd2 && !line_odd) |=> !cvld_o);     // R5
    AST_ABSENT_CHROMA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !cvld_o) |-> (u_o == '0 && v_o == '0));                         // R6
    AST_NO_IDLE_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !cvld_o);                                                       // R6
    AST_EXPAND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && act_dir && act_mode != 2'd0) |=> cvld_o);                    // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> ($stable(act_mode) && $stable(act_dir)));                 // R10

endmodule

bind chroma_resampler chroma_resampler_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .pix_valid_i   (pix_valid_i),
    .y_i           (y_i),
    .valid_o       (valid_o),
    .cvld_o        (cvld_o),
    .y_o           (y_o),
    .u_o           (u_o),
    .v_o           (v_o),
    .act_mode      (act_mode),
    .act_dir       (act_dir),
    .line_odd      (line_odd)
);

// File: tb/chroma_resampler_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module chroma_resampler_tb_top;

    localparam int DW    = 8;
    localparam int MAX_W = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = '0;
    logic          dir_i = 1'b0;
    logic          frame_start_i = 1'b0;
    logic          line_start_i = 1'b0;
    logic          pix_valid_i = 1'b0;
    logic [DW-1:0] y_i = '0, u_i = '0, v_i = '0;
    logic          valid_o, cvld_o;
    logic [DW-1:0] y_o, u_o, v_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    int m_mode = 0, m_dir = 0, m_line = 0, m_idx = 0;
    int hold_u = 0, hold_v = 0;
    int st_u [MAX_W];
    int st_v [MAX_W];
    bit e_valid = 0, e_cvld = 0;
    int e_y = 0, e_u = 0, e_v = 0;
    string e_tag = "R1";

    always #5 clk = ~clk;

    chroma_resampler #(.DW(DW), .MAX_W(MAX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i),
        .frame_start_i(frame_start_i), .line_start_i(line_start_i),
        .pix_valid_i(pix_valid_i), .y_i(y_i), .u_i(u_i), .v_i(v_i),
        .valid_o(valid_o), .cvld_o(cvld_o), .y_o(y_o), .u_o(u_o), .v_o(v_o)
    );

    task automatic compare();
        n_vec++;
        if (valid_o !== e_valid) begin
            n_bad++;
            $display("FAIL R1 valid_o got %0d exp %0d", valid_o, e_valid);
        end else if (e_valid) begin
            if (y_o !== DW'(e_y)) begin
                n_bad++;
                $display("FAIL R1 y_o got %0d exp %0d", y_o, e_y);
            end else if (cvld_o !== e_cvld || u_o !== DW'(e_u) || v_o !== DW'(e_v)) begin
                n_bad++;
                $display("FAIL %s cvld/u/v got %0d/%0d/%0d exp %0d/%0d/%0d",
                         e_tag, cvld_o, u_o, v_o, e_cvld, e_u, e_v);
            end
        end
        if (valid_o === 1'b1 && cvld_o === 1'b0 && (u_o !== '0 || v_o !== '0)) begin
            n_bad++;
            $display("FAIL R6 absent chroma got %0d/%0d exp 0/0", u_o, v_o);
        end
    endtask

    // One clock: drive at negedge, update the model, check at next negedge.
    task automatic tick(bit fs, bit ls, bit pv, int md, int dr);
        int y, u, v;
        bit colk, odd, keep;
        y = $urandom % 256; u = $urandom % 256; v = $urandom % 256;
        frame_start_i = fs; line_start_i = ls; pix_valid_i = pv;
        mode_i = 2'(md); dir_i = dr[0];
        y_i = DW'(y); u_i = DW'(u); v_i = DW'(v);
        if (fs) begin m_mode = md; m_dir = dr; m_line = 0; end
        if (ls) begin m_line++; m_idx = 0; end
        e_valid = pv; e_cvld = 0; e_u = 0; e_v = 0; e_y = y;
        if (pv) begin
            odd  = (m_line % 2) == 1;
            colk = (m_mode == 1 || m_mode == 2) ? (m_idx % 2 == 0) :
                   (m_mode == 3) ? (m_idx % 4 == 0) : 1'b0;
            if (m_dir == 0) begin
                keep = colk && (m_mode != 2 || odd);
                e_cvld = keep;
                if (keep) begin e_u = u; e_v = v; end
                e_tag = (m_mode == 0) ? "R2" : (m_mode == 1) ? "R3" :
                        (m_mode == 3) ? "R4" : "R5";
            end else if (m_mode == 0) begin
                e_tag = "R9";
            end else begin
                e_cvld = 1;
                if (m_mode == 2 && !odd) begin
                    e_u = st_u[m_idx]; e_v = st_v[m_idx];
                end else begin
                    if (colk) begin hold_u = u; hold_v = v; end
                    e_u = hold_u; e_v = hold_v;
                    if (m_mode == 2) begin st_u[m_idx] = e_u; st_v[m_idx] = e_v; end
                end
                e_tag = (m_mode == 2) ? "R8" : "R7";
            end
            if (md != m_mode || dr != m_dir) e_tag = "R10";
            m_idx++;
        end
        @(negedge clk);
        compare();
    endtask

    // Noise on the configuration inputs outside frame start (R10).
    task automatic idle();
        bit noisy = ($urandom % 3) == 0;
        tick(0, 0, 0, noisy ? int'($urandom % 4) : m_mode,
             noisy ? int'($urandom % 2) : m_dir);
    endtask

    task automatic frame(int md, int dr, int lines, int width);
        tick(1, 0, 0, md, dr);
        for (int l = 0; l < lines; l++) begin
            tick(0, 1, 0, md, dr);
            for (int p = 0; p < width; p++) begin
                bit noisy = ($urandom % 3) == 0;
                if ($urandom % 4 == 0) idle();
                tick(0, 0, 1, noisy ? int'($urandom % 4) : md,
                     noisy ? int'($urandom % 2) : dr);
            end
            idle();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (valid_o !== 1'b0 || cvld_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset state valid/cvld got %0d/%0d exp 0/0", valid_o, cvld_o);
        end
        for (int dr = 0; dr < 2; dr++)
            for (int md = 0; md < 4; md++) begin
                frame(md, dr, 4, 12);
                frame(md, dr, 3, 9);
            end
        frame(2, 1, 6, 17);
        frame(3, 1, 2, 13);
        frame(2, 0, 4, 7);
        repeat (2) idle();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule